// File: doc/BRIEF.md
# Rolled AES-128 encryption core with compressed round tables

This core encrypts one 128-bit block under a 128-bit key using AES-128. A single round datapath is reused for all ten rounds, so one block takes ten clock cycles. Each round is a set of lookups that combine SubBytes with the MixColumns coefficients. A table entry keeps only three bytes per input value: twice the substituted byte, the substituted byte, and three times it. The 32-bit column contribution is rebuilt by repeating the middle byte. The four rotated table variants are obtained by rewiring that word, so no extra storage is needed for them. The lookups are read synchronously, so the table output registers hold the round state.

Round keys are not expanded here. The core drives a round index to an external round-key store and reads the selected 128-bit key back in the same cycle. While idle the index is 0, so the whitening key is already present when a start arrives. The result appears on the output together with a one-cycle done pulse and stays there until the next result.

Top module: `aes128_tbox_enc`

## Requirements
- R1: The output equals the AES-128 encryption of the captured input block under the ten round keys read from the store. Key 000102030405060708090a0b0c0d0e0f with plaintext 00112233445566778899aabbccddeeff gives 69c4e0d86a7b0430d8cdb78070b4c55a. Byte 0 of every 128-bit value is bits [127:120].
- R2: done is high in the cycle that follows the tenth rising edge after the edge that captured start.
- R3: done is high for exactly one cycle per encryption.
- R4: A start that arrives while an encryption is in progress is ignored. The running result and its timing are unchanged, and no extra done follows.
- R5: rk_sel is 0 while idle. On the edge that captures start it becomes 1, then it rises by one each cycle up to 10, and on the edge that produces the result it returns to 0.
- R6: A start that is asserted in the cycle where done is high is accepted and gives a correct result ten cycles later.
- R7: blk_out changes only on the edge that raises done, and holds its value while the core is idle.
- R8: After reset, done is 0, blk_out is all zeros and rk_sel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin encrypting blk_in; used only while idle |
| blk_in | input | 128 | Plaintext block, byte 0 in bits [127:120] |
| rk_sel | output | 4 | Index of the round key requested from the store |
| rk_word | input | 128 | Round key selected by rk_sel, valid in the same cycle |
| blk_out | output | 128 | Ciphertext of the last completed block |
| done | output | 1 | One-cycle pulse when blk_out is updated |

## Verification
Every table entry and every round state bit feeds the whole state within two rounds. A wrong table byte, a miswired rotation or a ShiftRows slip therefore corrupts many ciphertext bytes, and this is visible at blk_out on the done cycle of the same block. To make sure every table address is looked up, the bench sweeps plaintexts made of one repeated byte value through all 256 values, and then runs varied keys against an arithmetic reference model. A counter or control fault shows up within one block as a done that arrives on the wrong cycle, as a rk_sel value out of sequence, or as a start that is wrongly accepted while the core is busy.

// File: rtl/aes128_tbox_enc.sv
module aes128_tbox_enc #(
  parameter int NR = 10,
  localparam int KW = $clog2(NR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [127:0]  blk_in,
  output logic [KW-1:0] rk_sel,
  input  logic [127:0]  rk_word,
  output logic [127:0]  blk_out,
  output logic          done
);

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] sb(input logic [7:0] a);
    logic [7:0] r, q;
    r = 8'h01;
    q = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gm(r, q);
      q = gm(q, q);
    end
    return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^ {r[3:0], r[7:4]} ^ 8'h63;
  endfunction

  logic [23:0] tbl [256];
  for (genvar g = 0; g < 256; g++) begin : g_tbl
    localparam logic [7:0] SV = sb(8'(g));
    assign tbl[g] = {xt(SV), SV, xt(SV) ^ SV};
  end

  logic [KW-1:0] rnd;
  logic [23:0]   tq [16];
  logic [127:0]  mixd, fin, nstate;
  logic          busy, load, last;

  assign busy   = (rnd != '0);
  assign last   = (rnd == KW'(NR));
  assign load   = (start && !busy) || (busy && !last);
  assign rk_sel = rnd;
  assign nstate = (busy ? mixd : blk_in) ^ rk_word;

  always_comb begin
    logic [31:0] w, t0;
    logic [63:0] dw;
    logic [23:0] e;
    mixd = '0;
    fin  = '0;
    for (int c = 0; c < 4; c++) begin
      w = '0;
      for (int r = 0; r < 4; r++) begin
        e  = tq[((c + r) % 4) * 4 + r];
        t0 = {e[23:16], e[15:8], e[15:8], e[7:0]};
        dw = {t0, t0} >> (8 * r);
        w ^= dw[31:0];
        fin[127 - 8 * (c * 4 + r) -: 8] = e[15:8];
      end
      mixd[127 - 32 * c -: 32] = w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rnd     <= '0;
      done    <= 1'b0;
      blk_out <= '0;
      for (int b = 0; b < 16; b++) tq[b] <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        for (int b = 0; b < 16; b++) tq[b] <= tbl[nstate[127 - 8 * b -: 8]];
        rnd <= rnd + 1'b1;
      end
      if (last) begin
        rnd     <= '0;
        blk_out <= fin ^ rk_word;
        done    <= 1'b1;
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rk_sel) == KW'(NR)); // R2
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rk_sel <= KW'(NR)); // R5
  AST_SEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_sel != '0 && rk_sel != KW'(NR)) |=> rk_sel == KW'($past(rk_sel) + 1'b1)); // R5
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && rk_sel != '0 && rk_sel != KW'(NR)) |=> rk_sel != KW'(1)); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(blk_out)); // R7

endmodule

// File: tb/sim_aes128_tbox_enc.sv
module sim_aes128_tbox_enc;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] blk_in = '0;
  logic [3:0]   rk_sel;
  logic [127:0] rk_word;
  logic [127:0] blk_out;
  logic         done;

  logic [127:0] rks [11];
  logic [7:0]   sbt [256];
  int           n_chk = 0, n_bad = 0;
  logic [63:0]  rng = 64'h9e3779b97f4a7c15;

  always #2 clk = ~clk;
  assign rk_word = rks[rk_sel];

  aes128_tbox_enc u0 (.clk(clk), .rst_n(rst_n), .start(start), .blk_in(blk_in),
                      .rk_sel(rk_sel), .rk_word(rk_word), .blk_out(blk_out), .done(done));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p ^= 16'(a) << i;
    for (int i = 15; i >= 8; i--) if (p[i]) p ^= 16'h011b << (i - 8);
    return p[7:0];
  endfunction

  function automatic logic [63:0] nxt();
    rng ^= rng << 13; rng ^= rng >> 7; rng ^= rng << 17;
    return rng;
  endfunction

  task automatic expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127 - 32 * i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i - 1];
      if (i % 4 == 0) begin
        t = {sbt[t[23:16]], sbt[t[15:8]], sbt[t[7:0]], sbt[t[31:24]]} ^ {rc, 24'h0};
        rc = mul(rc, 8'h02);
      end
      w[i] = w[i - 4] ^ t;
    end
    for (int r = 0; r < 11; r++) rks[r] = {w[4 * r], w[4 * r + 1], w[4 * r + 2], w[4 * r + 3]};
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] pt);
    logic [7:0] a [16];
    logic [7:0] o [16];
    logic [127:0] s;
    s = pt ^ rks[0];
    for (int r = 1; r <= 10; r++) begin
      for (int b = 0; b < 16; b++) a[b] = sbt[s[127 - 8 * b -: 8]];
      for (int c = 0; c < 4; c++)
        for (int k = 0; k < 4; k++) o[c * 4 + k] = a[((c + k) % 4) * 4 + k];
      if (r < 10)
        for (int c = 0; c < 4; c++) begin
          a[c*4]   = mul(o[c*4], 2) ^ mul(o[c*4+1], 3) ^ o[c*4+2] ^ o[c*4+3];
          a[c*4+1] = o[c*4] ^ mul(o[c*4+1], 2) ^ mul(o[c*4+2], 3) ^ o[c*4+3];
          a[c*4+2] = o[c*4] ^ o[c*4+1] ^ mul(o[c*4+2], 2) ^ mul(o[c*4+3], 3);
          a[c*4+3] = mul(o[c*4], 3) ^ o[c*4+1] ^ o[c*4+2] ^ mul(o[c*4+3], 2);
        end
      else
        for (int b = 0; b < 16; b++) a[b] = o[b];
      for (int b = 0; b < 16; b++) s[127 - 8 * b -: 8] = a[b];
      s ^= rks[r];
    end
    return s;
  endfunction

  // Called at a negedge; returns at the negedge where done is seen.
  task automatic run(input logic [127:0] pt, input bit inject, output logic [127:0] got);
    int cnt;
    bit sel_ok, fired;
    sel_ok = 1'b1;
    fired = 1'b0;
    start = 1'b1;
    blk_in = pt;
    @(negedge clk);
    start = 1'b0;
    blk_in = ~pt;
    chk(done == 1'b0, "R3 done single cycle", 128'(done), 128'(0));
    cnt = 0;
    while (!done && cnt < 40) begin
      if (rk_sel != 4'(cnt + 1)) sel_ok = 1'b0;
      if (inject && cnt == 4) start = 1'b1;   // R4 start while busy
      @(negedge clk);
      start = 1'b0;
      cnt++;
      if (done) fired = 1'b1;
    end
    chk(cnt == 10, "R2 latency", 128'(cnt), 128'(10));
    chk(sel_ok && rk_sel == 4'd0, "R5 key index sequence", 128'(rk_sel), 128'(0));
    got = blk_out;
  endtask

  initial begin
    logic [127:0] got, key, pt, exp, held;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv, y;
      inv = 8'h00;
      for (int v = 1; v < 256; v++) if (mul(8'(x), 8'(v)) == 8'h01) inv = 8'(v);
      for (int i = 0; i < 8; i++)
        y[i] = inv[i] ^ inv[(i + 4) % 8] ^ inv[(i + 5) % 8] ^ inv[(i + 6) % 8] ^ inv[(i + 7) % 8];
      sbt[x] = y ^ 8'h63;
    end
    key = 128'h000102030405060708090a0b0c0d0e0f;
    expand(key);
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && blk_out == '0 && rk_sel == 4'd0, "R8 reset state", blk_out, 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(rks[10] == 128'h13111d7fe3944a17f307a78b4d2b30c5, "R1 reference key schedule", rks[10],
        128'h13111d7fe3944a17f307a78b4d2b30c5);
    pt = 128'h00112233445566778899aabbccddeeff;
    run(pt, 1'b0, got);
    chk(got == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1 standard vector", got,
        128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    held = got;
    repeat (6) begin
      @(negedge clk);
      chk(blk_out == held && !done, "R7 output held while idle", blk_out, held);
    end
    // R6: back-to-back runs, every table address used in round 1
    for (int v = 0; v < 256; v++) begin
      pt = {16{8'(v)}};
      run(pt, 1'b0, got);
      exp = ref_enc(pt);
      chk(got == exp, "R1 R6 byte sweep", got, exp);
    end
    for (int k = 0; k < 16; k++) begin
      key = {nxt(), nxt()};
      expand(key);
      pt = {nxt(), nxt()};
      run(pt, (k % 4 == 1), got);
      exp = ref_enc(pt);
      chk(got == exp, (k % 4 == 1) ? "R4 busy start ignored" : "R1 varied key", got, exp);
      if (k % 4 == 1) begin
        @(negedge clk);
        chk(rk_sel == 4'd0 && !done, "R4 no extra run", 128'(rk_sel), 128'(0));
        @(negedge clk);
        chk(rk_sel == 4'd0 && !done, "R4 no extra run", 128'(rk_sel), 128'(0));
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule